// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block decides whether a received CAN frame header is kept, and which of two receive queues it goes to. It holds a bank of identical filters (fourteen by default). Each filter has two 32-bit pattern words and four control bits: enable, width, shape and queue select. The frame parser presents an identifier, an extended-format flag and a remote-request flag with a one-cycle strobe. One clock later the block returns an accept flag, the target queue and the number of the filter that accepted the frame.

A filter can work as one 32-bit identifier/mask pair, as two 16-bit identifier/mask pairs, as a list of two exact 32-bit words, or as a list of four exact 16-bit words. Configuration goes through a simple register write port. A global configuration-hold bit must be set while filters are being changed. While that bit is set, no frame is accepted.

Top module: `canid_filter_bank`

## Requirements
- R1: After synchronous reset, all result outputs are 0. The configuration-hold bit is 1, and every filter is disabled with both pattern words at 0.
- R2: A write on the configuration port uses this address map. Address 0, bit 0, is the configuration-hold bit. Addresses 1 to 4 are per-filter bit vectors: 1 is enable, 2 is width (1 = 32-bit), 3 is shape (1 = exact list), and 4 is queue select. Bit n of each vector belongs to filter n. Address 8+2n is word A of filter n, and 9+2n is word B. Writes to any address other than 0 are ignored while the hold bit is 0.
- R3: While the hold bit is 1, no frame is accepted.
- R4: `res_valid` is 1 exactly one cycle after `hdr_valid`. `res_accept` is never 1 without `res_valid`.
- R5: The header forms a 32-bit compare word and a 16-bit compare word. Let U be the 11-bit base identifier: `hdr_id[28:18]` for an extended frame and `hdr_id[10:0]` for a standard frame. Let E be `hdr_id[17:0]` for an extended frame and 0 otherwise. The 32-bit word is {U, E, ext, rtr, 0}. The 16-bit word is {U, rtr, ext, E[17:15]}.
- R6: In 32-bit mask form (width 1, shape 0), a filter matches when (word32 & B) == (A & B).
- R7: In 16-bit mask form (width 0, shape 0), a filter holds two pairs. The pairs are {A[31:16] id, A[15:0] mask} and {B[31:16] id, B[15:0] mask}. The filter matches if either pair matches word16 under its mask.
- R8: In 32-bit list form (width 1, shape 1), a filter matches when word32 equals A or equals B.
- R9: In 16-bit list form (width 0, shape 1), a filter matches when word16 equals any of A[31:16], A[15:0], B[31:16] or B[15:0].
- R10: A disabled filter never matches.
- R11: When several filters match, the lowest-numbered one is reported.
- R12: An accepted frame reports the winning filter's index and its queue select bit. A frame that matches no filter gives `res_accept` = 0, `res_index` = 0 and `res_fifo` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| hdr_valid | input | 1 | Frame header strobe |
| hdr_id | input | 29 | Identifier (standard in bits 10:0) |
| hdr_ext | input | 1 | Extended-format identifier flag |
| hdr_rtr | input | 1 | Remote request flag |
| res_valid | output | 1 | Result strobe, one cycle after the header |
| res_accept | output | 1 | Frame accepted |
| res_fifo | output | 1 | Target receive queue |
| res_index | output | IDX_W | Number of the accepting filter |

## Verification
The bench sends every standard identifier with both remote-flag values, plus a few hundred pseudo-random extended identifiers. It does this against a bank that holds one filter of each of the four forms, and the identifier ranges of those filters overlap on purpose. A sweep with a disabled catch-all filter tells match from no-match at every form's edges. The same sweep after the catch-all is enabled shows that lower-numbered filters keep priority. A final sweep with the hold bit set shows that nothing is accepted. Writes issued while the hold bit is clear must leave the results unchanged.

// File: rtl/canid_filt_pkg.sv
package canid_filt_pkg;

  localparam int CTRL_SPAN = 8;

  function automatic logic [31:0] hdr_word32(input logic [28:0] id, input logic ext, input logic rtr);
    logic [10:0] up;
    logic [17:0] lo;
    up = ext ? id[28:18] : id[10:0];
    lo = ext ? id[17:0] : 18'd0;
    return {up, lo, ext, rtr, 1'b0};
  endfunction

  function automatic logic [15:0] hdr_word16(input logic [28:0] id, input logic ext, input logic rtr);
    logic [10:0] up;
    logic [2:0]  lo;
    up = ext ? id[28:18] : id[10:0];
    lo = ext ? id[17:15] : 3'd0;
    return {up, rtr, ext, lo};
  endfunction

endpackage

// File: rtl/canid_filt_cfg.sv
module canid_filt_cfg #(
  parameter int NFILT  = 14,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output logic                    init_q,
  output logic [NFILT-1:0]        act_q,
  output logic [NFILT-1:0]        scl_q,
  output logic [NFILT-1:0]        mod_q,
  output logic [NFILT-1:0]        ffa_q,
  output logic [NFILT-1:0][31:0]  wa_q,
  output logic [NFILT-1:0][31:0]  wb_q
);
  import canid_filt_pkg::*;

  logic open_wr;
  assign open_wr = cfg_we && init_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= 1'b1;
      act_q  <= '0;
      scl_q  <= '0;
      mod_q  <= '0;
      ffa_q  <= '0;
    end else begin
      if (cfg_we && cfg_addr == ADDR_W'(0)) init_q <= cfg_wdata[0];
      if (open_wr && cfg_addr == ADDR_W'(1)) act_q <= cfg_wdata[NFILT-1:0];
      if (open_wr && cfg_addr == ADDR_W'(2)) scl_q <= cfg_wdata[NFILT-1:0];
      if (open_wr && cfg_addr == ADDR_W'(3)) mod_q <= cfg_wdata[NFILT-1:0];
      if (open_wr && cfg_addr == ADDR_W'(4)) ffa_q <= cfg_wdata[NFILT-1:0];
    end
  end

  for (genvar n = 0; n < NFILT; n++) begin : g_words
    always_ff @(posedge clk) begin
      if (rst) begin
        wa_q[n] <= '0;
        wb_q[n] <= '0;
      end else begin
        if (open_wr && cfg_addr == ADDR_W'(CTRL_SPAN + 2*n))     wa_q[n] <= cfg_wdata;
        if (open_wr && cfg_addr == ADDR_W'(CTRL_SPAN + 2*n + 1)) wb_q[n] <= cfg_wdata;
      end
    end
  end

endmodule

// File: rtl/canid_filt_match.sv
module canid_filt_match (
  input  logic [31:0] word32,
  input  logic [15:0] word16,
  input  logic [31:0] wa,
  input  logic [31:0] wb,
  input  logic        wide,
  input  logic        listed,
  input  logic        enabled,
  output logic        hit
);
  logic m32_mask, m32_list, m16_mask, m16_list;

  always_comb begin
    m32_mask = ((word32 ^ wa) & wb) == 32'd0;
    m32_list = (word32 == wa) || (word32 == wb);
    m16_mask = (((word16 ^ wa[31:16]) & wa[15:0]) == 16'd0) ||
               (((word16 ^ wb[31:16]) & wb[15:0]) == 16'd0);
    m16_list = (word16 == wa[31:16]) || (word16 == wa[15:0]) ||
               (word16 == wb[31:16]) || (word16 == wb[15:0]);
    unique case ({wide, listed})
      2'b10:   hit = m32_mask;
      2'b11:   hit = m32_list;
      2'b00:   hit = m16_mask;
      default: hit = m16_list;
    endcase
    hit = hit && enabled;
  end

endmodule

// File: rtl/canid_filt_prio.sv
module canid_filt_prio #(
  parameter int NFILT = 14,
  parameter int IDX_W = 4
) (
  input  logic [NFILT-1:0] hits,
  input  logic [NFILT-1:0] route,
  output logic             found,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_fifo
);
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_fifo = 1'b0;
    for (int n = NFILT - 1; n >= 0; n--) begin
      if (hits[n]) begin
        found    = 1'b1;
        win_idx  = IDX_W'(n);
        win_fifo = route[n];
      end
    end
  end

endmodule

// File: rtl/canid_filter_bank.sv
module canid_filter_bank #(
  parameter int NFILT  = 14,
  parameter int ADDR_W = $clog2(canid_filt_pkg::CTRL_SPAN + 2*NFILT),
  parameter int IDX_W  = (NFILT > 1) ? $clog2(NFILT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              hdr_valid,
  input  logic [28:0]       hdr_id,
  input  logic              hdr_ext,
  input  logic              hdr_rtr,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_fifo,
  output logic [IDX_W-1:0]  res_index
);
  import canid_filt_pkg::*;

  logic                   init_q;
  logic [NFILT-1:0]       act_q, scl_q, mod_q, ffa_q, hits;
  logic [NFILT-1:0][31:0] wa_q, wb_q;
  logic [31:0]            w32;
  logic [15:0]            w16;
  logic                   found, win_fifo;
  logic [IDX_W-1:0]       win_idx;

  canid_filt_cfg #(.NFILT(NFILT), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .init_q(init_q), .act_q(act_q), .scl_q(scl_q), .mod_q(mod_q), .ffa_q(ffa_q),
    .wa_q(wa_q), .wb_q(wb_q)
  );

  assign w32 = hdr_word32(hdr_id, hdr_ext, hdr_rtr);
  assign w16 = hdr_word16(hdr_id, hdr_ext, hdr_rtr);

  for (genvar n = 0; n < NFILT; n++) begin : g_filt
    canid_filt_match u_match (
      .word32(w32), .word16(w16), .wa(wa_q[n]), .wb(wb_q[n]),
      .wide(scl_q[n]), .listed(mod_q[n]), .enabled(act_q[n]), .hit(hits[n])
    );
  end

  canid_filt_prio #(.NFILT(NFILT), .IDX_W(IDX_W)) u_prio (
    .hits(hits), .route(ffa_q), .found(found), .win_idx(win_idx), .win_fifo(win_fifo)
  );

  logic take;
  assign take = hdr_valid && found && !init_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_fifo   <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid  <= hdr_valid;
      res_accept <= take;
      res_fifo   <= take ? win_fifo : 1'b0;
      res_index  <= take ? win_idx : '0;
    end
  end

endmodule

// File: rtl/canid_filter_bank_chk.sv
module canid_filter_bank_chk #(
  parameter int NFILT = 14,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hdr_valid,
  input logic             res_valid,
  input logic             res_accept,
  input logic             res_fifo,
  input logic [IDX_W-1:0] res_index,
  input logic             init_q,
  input logic [NFILT-1:0] act_q,
  input logic [NFILT-1:0] ffa_q
);
  logic             init_d;
  logic [NFILT-1:0] act_d, ffa_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_d <= 1'b1;
      act_d  <= '0;
      ffa_d  <= '0;
    end else begin
      init_d <= init_q;
      act_d  <= act_q;
      ffa_d  <= ffa_q;
    end
  end

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst) res_accept |-> !init_d); // R3
  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (rst) res_accept |-> res_valid); // R4
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst) hdr_valid |=> res_valid); // R4
  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (rst) res_accept |-> act_d[res_index]); // R10
  AST_QUEUE_ROUTE: assert property (@(posedge clk) disable iff (rst) res_accept |-> (res_fifo == ffa_d[res_index])); // R12
  AST_DROP_CLEAN: assert property (@(posedge clk) disable iff (rst) !res_accept |-> (res_index == '0 && !res_fifo)); // R12
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst) int'(res_index) < NFILT); // R12

endmodule

bind canid_filter_bank canid_filter_bank_chk #(.NFILT(NFILT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .res_valid(res_valid),
  .res_accept(res_accept), .res_fifo(res_fifo), .res_index(res_index),
  .init_q(init_q), .act_q(act_q), .ffa_q(ffa_q)
);

// File: tb/canid_filter_bank_bench.sv
module canid_filter_bank_bench;
  localparam int NF = 14;
  localparam int AW = $clog2(8 + 2*NF);
  localparam int IW = $clog2(NF);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic hdr_valid = 1'b0, hdr_ext = 1'b0, hdr_rtr = 1'b0;
  logic [28:0] hdr_id = '0;
  logic res_valid, res_accept, res_fifo;
  logic [IW-1:0] res_index;

  int checks = 0, errors = 0;

  logic          m_init;
  logic [NF-1:0] m_act, m_scl, m_mod, m_ffa;
  logic [31:0]   m_a [NF];
  logic [31:0]   m_b [NF];

  always #5 clk = ~clk;

  canid_filter_bank u_canid_filter_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hdr_valid(hdr_valid), .hdr_id(hdr_id), .hdr_ext(hdr_ext), .hdr_rtr(hdr_rtr),
    .res_valid(res_valid), .res_accept(res_accept), .res_fifo(res_fifo), .res_index(res_index)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr == 0) m_init = data[0];
    else if (m_init) begin
      if (addr == 1) m_act = data[NF-1:0];
      else if (addr == 2) m_scl = data[NF-1:0];
      else if (addr == 3) m_mod = data[NF-1:0];
      else if (addr == 4) m_ffa = data[NF-1:0];
      else if (addr >= 8) begin
        if (addr % 2 == 0) m_a[(addr-8)/2] = data;
        else m_b[(addr-8)/2] = data;
      end
    end
  endtask

  // Reference built from R5..R12
  task automatic model(input logic [28:0] id, input logic e, input logic r,
                       output logic acc, output logic fq, output int idx, output string tag);
    logic [10:0] up = e ? id[28:18] : id[10:0];
    logic [17:0] lo = e ? id[17:0] : 18'd0;
    logic [31:0] x32 = {up, lo, e, r, 1'b0};
    logic [15:0] x16 = {up, r, e, lo[17:15]};
    acc = 1'b0; fq = 1'b0; idx = 0; tag = "R12";
    for (int n = 0; n < NF; n++) begin
      logic h;
      if (m_scl[n] && !m_mod[n]) h = (x32 & m_b[n]) == (m_a[n] & m_b[n]);
      else if (m_scl[n]) h = (x32 == m_a[n]) || (x32 == m_b[n]);
      else if (!m_mod[n]) h = ((x16 & m_a[n][15:0]) == (m_a[n][31:16] & m_a[n][15:0])) ||
                              ((x16 & m_b[n][15:0]) == (m_b[n][31:16] & m_b[n][15:0]));
      else h = (x16 == m_a[n][31:16]) || (x16 == m_a[n][15:0]) ||
               (x16 == m_b[n][31:16]) || (x16 == m_b[n][15:0]);
      if (h && m_act[n] && !acc) begin
        acc = 1'b1; fq = m_ffa[n]; idx = n;
        tag = m_scl[n] ? (m_mod[n] ? "R8" : "R6") : (m_mod[n] ? "R9" : "R7");
        if (n > 0) tag = {tag, "/R11"};
      end
    end
    if (m_init) begin acc = 1'b0; fq = 1'b0; idx = 0; tag = "R3"; end
  endtask

  task automatic send(input logic [28:0] id, input logic e, input logic r);
    logic acc, fq; int idx; string tag;
    model(id, e, r, acc, fq, idx, tag);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_id = id; hdr_ext = e; hdr_rtr = r;
    @(negedge clk);
    hdr_valid = 1'b0;
    check({"R4 valid ", tag}, 32'(res_valid), 32'd1);
    check({"accept ", tag}, {res_index, res_fifo, res_accept}, {IW'(idx), fq, acc});
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lf = 32'h1ACE_5EED;
    m_init = 1'b1; m_act = '0; m_scl = '0; m_mod = '0; m_ffa = '0;
    for (int n = 0; n < NF; n++) begin m_a[n] = '0; m_b[n] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 outputs", {res_index, res_fifo, res_accept, res_valid}, '0);
    send(29'h120, 1'b0, 1'b0);
    // R4: strobe drops the cycle after
    @(negedge clk);
    check("R4 single strobe", 32'(res_valid), 32'd0);

    // Configure one filter of each form; filter 4 is a disabled catch-all
    wr(8,  32'h120 << 21);                 // F0 32-bit mask: std 0x120..0x12F
    wr(9,  (32'h7F0 << 21) | 32'h4);
    wr(10, 32'h6000_FFF8);                 // F1 16-bit mask pairs
    wr(11, 32'h8000_F808);
    wr(12, {29'h1234567, 3'b100});         // F2 32-bit list: ext 0x1234567 / std 0x7FF rtr
    wr(13, (32'h7FF << 21) | 32'h2);
    wr(14, {11'h010, 5'd0, 11'h020, 5'd0}); // F3 16-bit list
    wr(15, {11'h125, 5'd0, 11'h555, 5'h10});
    wr(16, 32'h0); wr(17, 32'h0);          // F4 catch-all
    wr(2, 32'b00101);
    wr(3, 32'b01100);
    wr(4, 32'b11100);
    wr(1, 32'b01111);
    send(29'h120, 1'b0, 1'b0);             // R3: still held
    wr(0, 32'h0);
    // R2: writes ignored with hold clear
    wr(9, 32'h0); wr(1, 32'h1F);
    send(29'h700, 1'b0, 1'b0);
    // R5: extended header packing reaches the 32-bit list entry
    send(29'h1234567, 1'b1, 1'b0);
    send(29'h1234567, 1'b1, 1'b1);
    // Phase A: full standard sweep, R10 via disabled catch-all
    for (int i = 0; i < 2048; i++)
      for (int r = 0; r < 2; r++) send(29'(i), 1'b0, r[0]);
    for (int i = 0; i < 300; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      send(lf[28:0], 1'b1, lf[31]);
    end
    // Phase B: enable catch-all; lower filters keep priority (R11)
    wr(0, 32'h1); wr(1, 32'b11111); wr(0, 32'h0);
    for (int i = 0; i < 2048; i++)
      for (int r = 0; r < 2; r++) send(29'(i), 1'b0, r[0]);
    send(29'h1234567, 1'b1, 1'b0);
    // Phase C: hold set, nothing accepted (R3)
    wr(0, 32'h1);
    for (int i = 0; i < 2048; i += 8) send(29'(i), 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule